// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms 32-bit operand and branch-target addresses for a 32-bit load/store processor core. Each request arrives as a single-cycle start strobe. With it come a two-bit mode, an access size, an 8-bit displacement field, and the values of the index register R0, the global base register, the table base register and the program counter. The requester does not need to know the mode of the result. Every result appears on one address bus, qualified by a one-cycle result-valid pulse.

Three of the modes are direct and finish in one cycle: global base plus R0, PC-relative data with a scaled displacement, and PC-relative branch with a signed displacement. The fourth mode, table-indirect, computes a pointer address from the table base register. It reads a 32-bit word from memory at that address over a level request / read-valid port, and returns that word as the result. While this read is outstanding, the unit reports busy and ignores any new start strobe.

Top module: `eagen_unit`

## Requirements
- R1: Mode 0 (global base indexed) yields global base + R0; the displacement and size inputs have no effect.
- R2: Mode 1 with a word access (long_i = 0) yields PC + zero-extended displacement × 2, with the PC unmasked.
- R3: Mode 1 with a longword access (long_i = 1) yields (PC AND 0xFFFFFFFC) + zero-extended displacement × 4.
- R4: Mode 2 (branch) yields PC + sign-extended displacement × 2.
- R5: Mode 3 (table-indirect) raises mem_req_o and busy_o in the cycle after start. mem_addr_o carries table base + zero-extended displacement × 4 and holds steady until read-valid is sampled.
- R6: In mode 3, the cycle after mem_rvalid_i is sampled high during a read, res_valid_o pulses, res_addr_o equals the returned mem_rdata_i, and busy_o and mem_req_o fall.
- R7: For modes 0–2, res_valid_o is high for exactly the one cycle after start, and busy_o stays low.
- R8: A start strobe sampled while busy_o is high is dropped. It does not change the request address and produces no result, either during the read or after it.
- R9: All address sums wrap modulo 2^32, with no overflow indication.
- R10: Reset (rst_n low, asynchronous) clears busy_o, res_valid_o and mem_req_o, including in the middle of a table read.
- R11: res_addr_o holds its last result until the next result. A mem_rvalid_i pulse while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | One-cycle request strobe |
| mode_i | input | 2 | 0 base+index, 1 PC data, 2 PC branch, 3 table-indirect |
| long_i | input | 1 | Access size: 1 longword, 0 word |
| disp_i | input | 8 | Displacement field |
| r0_i | input | 32 | Index register value |
| gbr_i | input | 32 | Global base register value |
| tbr_i | input | 32 | Table base register value |
| pc_i | input | 32 | Program counter value |
| busy_o | output | 1 | Table read outstanding; starts are ignored |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_addr_o | output | 32 | Resulting address |
| mem_req_o | output | 1 | Memory read request, held until read-valid |
| mem_addr_o | output | 32 | Pointer address for the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (the pointer) |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath and an 8-bit displacement. All 256 displacement values therefore get swept in every mode and size. Each sweep runs against several base values, including bases near 0xFFFFFFFF and near zero, so that sign extension, PC masking with misaligned PCs, and modulo-2^32 wrap are all reached. Table-indirect reads use read-valid delays from zero to three cycles. Extra starts are injected during the wait, and reset is applied in the middle of a read.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

  typedef enum logic [1:0] {
    EA_GBR_IDX   = 2'd0,
    EA_PC_DATA   = 2'd1,
    EA_PC_BRANCH = 2'd2,
    EA_TABLE     = 2'd3
  } ea_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;

endpackage

// File: rtl/eagen_disp.sv
// Extends and scales the displacement field for the selected mode.
module eagen_disp
  import eagen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic [1:0]        mode_i,
  input  logic              long_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] offset_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] zext;
  logic [ADDR_W-1:0] sext;

  assign zext = {{EXT_W{1'b0}}, disp_i};
  assign sext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};

  always_comb begin
    unique case (ea_mode_e'(mode_i))
      EA_GBR_IDX:   offset_o = '0;
      EA_PC_DATA:   offset_o = long_i ? (zext << 2) : (zext << 1);
      EA_PC_BRANCH: offset_o = sext << 1;
      EA_TABLE:     offset_o = zext << 2;
      default:      offset_o = '0;
    endcase
  end
endmodule

// File: rtl/eagen_base.sv
// Picks the base operand; masks the PC for longword data reads.
module eagen_base
  import eagen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] r0_i,
  input  logic [ADDR_W-1:0] gbr_i,
  input  logic [ADDR_W-1:0] tbr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] addend_o
);
  localparam logic [ADDR_W-1:0] LONG_MASK = ~ADDR_W'(3);

  always_comb begin
    addend_o = '0;
    unique case (ea_mode_e'(mode_i))
      EA_GBR_IDX: begin
        base_o   = gbr_i;
        addend_o = r0_i;
      end
      EA_PC_DATA:   base_o = long_i ? (pc_i & LONG_MASK) : pc_i;
      EA_PC_BRANCH: base_o = pc_i;
      EA_TABLE:     base_o = tbr_i;
      default:      base_o = '0;
    endcase
  end
endmodule

// File: rtl/eagen_ctrl.sv
// Sequencer: direct results in one cycle, table reads in two steps.
module eagen_ctrl
  import eagen_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_table_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  ea_state_e         state_q, state_d;
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] res_q, res_d;
  logic              res_en;
  logic [ADDR_W-1:0] ptr_q;
  logic              ptr_en;

  always_comb begin
    state_d = state_q;
    valid_d = 1'b0;
    res_d   = res_q;
    res_en  = 1'b0;
    ptr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (is_table_i) begin
            state_d = ST_WAIT;
            ptr_en  = 1'b1;
          end else begin
            valid_d = 1'b1;
            res_d   = ea_i;
            res_en  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (mem_rvalid_i) begin
          state_d = ST_IDLE;
          valid_d = 1'b1;
          res_d   = mem_rdata_i;
          res_en  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      res_q   <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      if (res_en) res_q <= res_d;
      if (ptr_en) ptr_q <= ea_i;
    end
  end

  assign busy_o      = (state_q == ST_WAIT);
  assign mem_req_o   = (state_q == ST_WAIT);
  assign mem_addr_o  = ptr_q;
  assign res_valid_o = valid_q;
  assign res_addr_o  = res_q;
endmodule

// File: rtl/eagen_unit.sv
module eagen_unit
  import eagen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              long_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] r0_i,
  input  logic [ADDR_W-1:0] gbr_i,
  input  logic [ADDR_W-1:0] tbr_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] res_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] addend;
  logic [ADDR_W-1:0] ea;

  eagen_disp #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_disp (
    .mode_i   (mode_i),
    .long_i   (long_i),
    .disp_i   (disp_i),
    .offset_o (offset)
  );

  eagen_base #(.ADDR_W(ADDR_W)) u_base (
    .mode_i   (mode_i),
    .long_i   (long_i),
    .r0_i     (r0_i),
    .gbr_i    (gbr_i),
    .tbr_i    (tbr_i),
    .pc_i     (pc_i),
    .base_o   (base),
    .addend_o (addend)
  );

  // Single shared adder; the sum wraps modulo 2^ADDR_W.
  assign ea = base + offset + addend;

  eagen_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .is_table_i   (mode_i == EA_TABLE),
    .ea_i         (ea),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (busy_o),
    .res_valid_o  (res_valid_o),
    .res_addr_o   (res_addr_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o)
  );
endmodule

// File: rtl/eagen_unit_chk.sv
module eagen_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        mode_i,
  input logic [ADDR_W-1:0] r0_i,
  input logic [ADDR_W-1:0] gbr_i,
  input logic              busy_o,
  input logic              res_valid_o,
  input logic [ADDR_W-1:0] res_addr_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic [ADDR_W-1:0] mem_rdata_i
);
  // R7
  direct_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mode_i != 2'd3) |=> (res_valid_o && !busy_o));

  // R1
  gbr_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mode_i == 2'd0) |=> (res_addr_o == $past(gbr_i) + $past(r0_i)));

  // R5
  table_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && mode_i == 2'd3) |=> (mem_req_o && busy_o && !res_valid_o));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R6
  table_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_rvalid_i) |=> (res_valid_o && !busy_o && !mem_req_o && res_addr_o == $past(mem_rdata_i)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mem_rvalid_i) |=> !res_valid_o);

  // R11
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_o |-> $stable(res_addr_o));
endmodule

bind eagen_unit eagen_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .mode_i       (mode_i),
  .r0_i         (r0_i),
  .gbr_i        (gbr_i),
  .busy_o       (busy_o),
  .res_valid_o  (res_valid_o),
  .res_addr_o   (res_addr_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rdata_i  (mem_rdata_i)
);

// File: tb/eagen_unit_bench.sv
`timescale 1ns/1ps
module eagen_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic        long_i;
  logic [7:0]  disp_i;
  logic [31:0] r0_i, gbr_i, tbr_i, pc_i;
  logic        busy_o, res_valid_o, mem_req_o;
  logic [31:0] res_addr_o, mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  eagen_unit u_eagen_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .long_i(long_i),
    .disp_i(disp_i), .r0_i(r0_i), .gbr_i(gbr_i), .tbr_i(tbr_i), .pc_i(pc_i),
    .busy_o(busy_o), .res_valid_o(res_valid_o), .res_addr_o(res_addr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] base_pick(input int k);
    case (k)
      0: return 32'h0000_1000;
      1: return 32'h0000_1003;
      2: return 32'hFFFF_FFF2;
      default: return 32'h0000_0001;
    endcase
  endfunction

  // Direct request: the result appears in the cycle after start.
  task automatic do_direct(input logic [1:0] m, input logic lg, input logic [7:0] d,
                           input logic [31:0] r0, input logic [31:0] g, input logic [31:0] p,
                           input logic [31:0] exp, input string req);
    mode_i = m; long_i = lg; disp_i = d; r0_i = r0; gbr_i = g; pc_i = p;
    tbr_i = ~p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(req, "address", res_addr_o, exp);
    chk("R7", "valid pulse", {31'd0, res_valid_o}, 32'd1);
    chk("R7", "busy low", {31'd0, busy_o}, 32'd0);
    @(negedge clk);
    chk("R7", "valid falls", {31'd0, res_valid_o}, 32'd0);
    chk("R11", "result held", res_addr_o, exp);
  endtask

  // Table read with a given read-valid delay and starts injected while waiting.
  task automatic do_table(input logic [7:0] d, input logic [31:0] t, input int dly,
                          input logic [31:0] rdata);
    logic [31:0] ptr;
    ptr = t + ({24'd0, d} << 2);
    mode_i = 2'd3; long_i = d[0]; disp_i = d; tbr_i = t; pc_i = ~t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R5", "req raised", {30'd0, mem_req_o, busy_o}, 32'd3);
    chk("R5", "pointer addr", mem_addr_o, ptr);
    chk("R5", "no result yet", {31'd0, res_valid_o}, 32'd0);
    for (int i = 0; i < dly; i++) begin
      start_i = 1'b1; mode_i = i[1:0]; disp_i = ~d; tbr_i = t ^ 32'h55;
      @(negedge clk);
      chk("R8", "no result while busy", {31'd0, res_valid_o}, 32'd0);
      chk("R8", "addr unchanged", mem_addr_o, ptr);
      chk("R5", "req held", {31'd0, mem_req_o}, 32'd1);
    end
    mem_rvalid_i = 1'b1; mem_rdata_i = rdata;
    start_i = (dly != 0);
    mode_i = 2'd0;
    @(negedge clk);
    start_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = ~rdata;
    chk("R6", "result valid", {31'd0, res_valid_o}, 32'd1);
    chk("R6", "result data", res_addr_o, rdata);
    chk("R6", "busy/req low", {30'd0, mem_req_o, busy_o}, 32'd0);
    @(negedge clk);
    chk("R8", "no late result", {31'd0, res_valid_o}, 32'd0);
    chk("R8", "no new request", {31'd0, mem_req_o}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = '0; long_i = 1'b0; disp_i = '0;
    r0_i = '0; gbr_i = '0; tbr_i = '0; pc_i = '0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {29'd0, busy_o, res_valid_o, mem_req_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < 256; d++) begin
        logic [31:0] b, r0v, sx;
        logic [7:0]  d8;
        b   = base_pick(k);
        d8  = d[7:0];
        r0v = (k == 2) ? (32'h20 + 32'(d)) : (32'h0001_0000 * 32'(d));
        do_direct(2'd0, d8[1], d8, r0v, b, ~b, b + r0v, "R1");
        do_direct(2'd1, 1'b0, d8, ~b, ~b, b, b + 32'(d) * 2, "R2");
        do_direct(2'd1, 1'b1, d8, ~b, ~b, b, (b & 32'hFFFF_FFFC) + 32'(d) * 4, "R3");
        sx = (d < 128) ? 32'(d) : (32'(d) - 32'd256);
        do_direct(2'd2, d8[0], d8, ~b, ~b, b, b + sx * 2, "R4");
      end
    end

    // R9: explicit wrap corners
    do_direct(2'd0, 1'b0, 8'h00, 32'h0000_0010, 32'hFFFF_FFF8, 32'h0, 32'h0000_0008, "R9");
    do_direct(2'd2, 1'b0, 8'hFF, 32'h0, 32'h0, 32'h0000_0000, 32'hFFFF_FFFE, "R9");
    do_direct(2'd1, 1'b1, 8'hFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_03F8, "R9");

    for (int d = 0; d < 256; d++) begin
      logic [31:0] t;
      t = (d % 3 == 0) ? 32'hFFFF_FF80 : (32'h0004_0000 + 32'(d) * 32'h111);
      do_table(d[7:0], t, d % 4, 32'hA5A5_0000 ^ (32'(d) << 8) ^ 32'(d));
    end

    // R11: read-valid while idle is ignored
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'hDEAD_BEEF;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk("R11", "idle rvalid no result", {31'd0, res_valid_o}, 32'd0);
    chk("R11", "idle rvalid holds addr", res_addr_o, 32'hA5A5_FFFF ^ 32'hFF00 ^ 32'hFF00);

    // R10: reset in the middle of a table read
    mode_i = 2'd3; disp_i = 8'h10; tbr_i = 32'h100; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R10", "busy before reset", {31'd0, busy_o}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R10", "cleared mid-read", {29'd0, busy_o, res_valid_o, mem_req_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    mem_rvalid_i = 1'b1; mem_rdata_i = 32'h1234_5678;
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    chk("R10", "stale read ignored", {31'd0, res_valid_o}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule